// File: doc/BRIEF.md
# Address-Range Remote Write Forwarder

This block sits in an I/O port and takes posted extended writes from the system bus. Each write carries a 40-bit physical address and a payload of 32 or 64 bytes. The block compares the address against two programmable inclusive windows, one per downstream link. The first window that matches picks the link. The write is then held in a single-entry buffer.

While the write is held, the block waits until the remote adapter on the chosen link signals a free buffer. It then emits the outbound packet in a single cycle. The packet holds the address, the size flag and the full payload with no byte masking. On the cycle after the packet, the block issues a credit-return CSR write to a fixed broadcast address. The buffer stays occupied until that link's status return arrives. A failing status raises a sticky error flag and a one-cycle interrupt pulse. A write that hits neither window is dropped and sets a sticky flag.

Top module: `xwf_forwarder`

## Requirements
- R1: The window registers are written through `cfg_we`, `cfg_sel` and `cfg_wdata`, with select code 0 = window 0 low bound, 1 = window 0 high bound, 2 = window 1 low bound and 3 = window 1 high bound. After reset every low bound is all ones and every high bound is zero, so no address matches until the registers are programmed.
- R2: A window matches when low ≤ address ≤ high, with both ends inclusive. The index of the matching window is the link number reported on `pkt_link`.
- R3: When an address lies inside both windows, link 0 is chosen.
- R4: A write accepted while it matches no window is dropped: no packet is produced and `in_ready` stays high. `unm_flag` rises on the next cycle and stays high until reset.
- R5: `in_ready` is high exactly when the buffer is empty. A write offered while `in_ready` is low is ignored, and no packet for it ever appears.
- R6: A buffered write waits while `lnk_free[link]` is low. Once `lnk_free[link]` is sampled high, `pkt_valid` pulses for one cycle on the next cycle, carrying the buffered address on `pkt_addr`.
- R7: `pkt_long` repeats the write's size flag (1 = 64 bytes). A 64-byte write carries all 512 data bits. A 32-byte write carries the low 256 bits, and the upper 256 bits of `pkt_data` are zero.
- R8: On the cycle after each packet, `csr_valid` pulses for one cycle with `csr_addr` = broadcast base + 0x640 when the port is node 8, or + 0x600 when it is node 4 to 7.
- R9: After the credit write, the buffer is freed only by `sts_valid` on the link that carried the packet, whether the status reports success or failure. A status on the other link is ignored. `in_ready` rises on the cycle after the accepted status.
- R10: An accepted status with `sts_fail` high sets the sticky `err_flag` and pulses `err_irq` for exactly one cycle, both on the next cycle.
- R11: While reset is held and after it is released, `in_ready` is high, all flags are low, and `pkt_valid` and `csr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select |
| cfg_wdata | input | 40 | Window register write value |
| in_valid | input | 1 | Extended write offered |
| in_ready | output | 1 | Buffer empty, write accepted |
| in_addr | input | 40 | Write physical address |
| in_long | input | 1 | 1 = 64-byte payload, 0 = 32-byte |
| in_data | input | 512 | Write payload |
| lnk_free | input | 2 | Remote adapter buffer available, per link |
| pkt_valid | output | 1 | Outbound packet strobe |
| pkt_link | output | 1 | Link carrying the packet |
| pkt_addr | output | 40 | Packet address |
| pkt_long | output | 1 | Packet size flag |
| pkt_data | output | 512 | Packet payload |
| csr_valid | output | 1 | Credit-return CSR write strobe |
| csr_addr | output | 40 | Credit-return CSR address |
| sts_valid | input | 2 | Status return received, per link |
| sts_fail | input | 1 | Status reports failure |
| unm_flag | output | 1 | Sticky unmatched-write flag |
| err_flag | output | 1 | Sticky failure-status flag |
| err_irq | output | 1 | One-cycle failure interrupt pulse |

## Verification
The assertions assume the remote side behaves well: a status return arrives only for a packet that is outstanding, and window registers are not rewritten in the same cycle as a write they would decode. The stimulus respects both. It programs the windows before any matched traffic, raises `sts_valid` only after the credit write has been seen, and offers extra writes only while the buffer is busy. Each of those extra writes must leave no trace at the outputs.

// File: rtl/xwf_pkg.sv
package xwf_pkg;

   typedef enum logic [2:0] {
      ST_EMPTY = 3'd0,
      ST_PEND  = 3'd1,
      ST_SEND  = 3'd2,
      ST_CRED  = 3'd3,
      ST_ACKW  = 3'd4
   } fwd_st_e;

   function automatic int link_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xwf_range_regs.sv
module xwf_range_regs #(
   parameter int ADDR_W  = 40,
   parameter int N_RANGE = 2,
   localparam int SEL_W  = $clog2(2 * N_RANGE)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [SEL_W-1:0]                cfg_sel,
   input  logic [ADDR_W-1:0]               cfg_wdata,
   output logic [N_RANGE-1:0][ADDR_W-1:0]  lo_q,
   output logic [N_RANGE-1:0][ADDR_W-1:0]  hi_q
);

   for (genvar g = 0; g < N_RANGE; g++) begin : g_win
      localparam int LO_CODE = 2 * g;
      localparam int HI_CODE = 2 * g + 1;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q[g] <= '1;
            hi_q[g] <= '0;
         end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(LO_CODE)) lo_q[g] <= cfg_wdata;
            if (cfg_sel == SEL_W'(HI_CODE)) hi_q[g] <= cfg_wdata;
         end
      end
   end

endmodule

// File: rtl/xwf_match.sv
module xwf_match #(
   parameter int ADDR_W  = 40,
   parameter int N_RANGE = 2,
   localparam int LNK_W  = xwf_pkg::link_bits(N_RANGE)
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [N_RANGE-1:0][ADDR_W-1:0]  lo_q,
   input  logic [N_RANGE-1:0][ADDR_W-1:0]  hi_q,
   output logic                            any_hit,
   output logic [LNK_W-1:0]                hit_idx
);

   logic [N_RANGE-1:0] hit;

   for (genvar g = 0; g < N_RANGE; g++) begin : g_cmp
      assign hit[g] = (addr >= lo_q[g]) && (addr <= hi_q[g]);
   end

   // lowest index wins
   always_comb begin
      hit_idx = '0;
      for (int i = N_RANGE - 1; i >= 0; i--) begin
         if (hit[i]) hit_idx = LNK_W'(i);
      end
   end

   assign any_hit = |hit;

endmodule

// File: rtl/xwf_ctrl.sv
module xwf_ctrl
   import xwf_pkg::*;
#(
   parameter int              ADDR_W     = 40,
   parameter int              DATA_W     = 512,
   parameter int              N_RANGE    = 2,
   parameter int              NODE_ID    = 8,
   parameter logic [ADDR_W-1:0] BCAST_BASE = '0,
   localparam int             LNK_W      = link_bits(N_RANGE),
   localparam int             HALF_W     = DATA_W / 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic                in_long,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                any_hit,
   input  logic [LNK_W-1:0]    hit_idx,
   output logic                in_ready,
   input  logic [N_RANGE-1:0]  lnk_free,
   input  logic [N_RANGE-1:0]  sts_valid,
   input  logic                sts_fail,
   output logic                pkt_valid,
   output logic [LNK_W-1:0]    pkt_link,
   output logic [ADDR_W-1:0]   pkt_addr,
   output logic                pkt_long,
   output logic [DATA_W-1:0]   pkt_data,
   output logic                csr_valid,
   output logic [ADDR_W-1:0]   csr_addr,
   output logic                unm_flag,
   output logic                err_flag,
   output logic                err_irq
);

   localparam logic [11:0]       DQ_OFS  = (NODE_ID == 8) ? 12'h640 : 12'h600;
   localparam logic [ADDR_W-1:0] DQ_ADDR = BCAST_BASE + ADDR_W'(DQ_OFS);

   fwd_st_e             st_q;
   logic [LNK_W-1:0]    lnk_q;
   logic [ADDR_W-1:0]   adr_q;
   logic                long_q;
   logic [DATA_W-1:0]   dat_q;
   logic                take;

   assign take = in_valid && (st_q == ST_EMPTY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_EMPTY;
         lnk_q    <= '0;
         adr_q    <= '0;
         long_q   <= 1'b0;
         dat_q    <= '0;
         unm_flag <= 1'b0;
         err_flag <= 1'b0;
         err_irq  <= 1'b0;
      end else begin
         err_irq <= 1'b0;
         unique case (st_q)
            ST_EMPTY: if (take) begin
               if (any_hit) begin
                  st_q   <= ST_PEND;
                  lnk_q  <= hit_idx;
                  adr_q  <= in_addr;
                  long_q <= in_long;
                  dat_q  <= in_long ? in_data : {{HALF_W{1'b0}}, in_data[HALF_W-1:0]};
               end else begin
                  unm_flag <= 1'b1;
               end
            end
            ST_PEND: if (lnk_free[lnk_q]) st_q <= ST_SEND;
            ST_SEND: st_q <= ST_CRED;
            ST_CRED: st_q <= ST_ACKW;
            ST_ACKW: if (sts_valid[lnk_q]) begin
               st_q <= ST_EMPTY;
               if (sts_fail) begin
                  err_flag <= 1'b1;
                  err_irq  <= 1'b1;
               end
            end
            default: st_q <= ST_EMPTY;
         endcase
      end
   end

   assign in_ready  = (st_q == ST_EMPTY);
   assign pkt_valid = (st_q == ST_SEND);
   assign pkt_link  = lnk_q;
   assign pkt_addr  = adr_q;
   assign pkt_long  = long_q;
   assign pkt_data  = dat_q;
   assign csr_valid = (st_q == ST_CRED);
   assign csr_addr  = DQ_ADDR;

   a_r6_pkt_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> $past(lnk_free[pkt_link]));
   a_r6_pkt_single: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> !pkt_valid);
   a_r8_credit_follows_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      csr_valid |-> $past(pkt_valid));
   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_valid && csr_valid));
   a_r5_fill_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid && any_hit));
   a_r4_unm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unm_flag |=> unm_flag);
   a_r10_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> err_flag);
   a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |=> !err_irq);
   a_r9_free_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(sts_valid[pkt_link]));

endmodule

// File: rtl/xwf_forwarder.sv
module xwf_forwarder #(
   parameter int              ADDR_W     = 40,
   parameter int              DATA_W     = 512,
   parameter int              N_RANGE    = 2,
   parameter int              NODE_ID    = 8,
   parameter logic [ADDR_W-1:0] BCAST_BASE = 40'hFF_8000_0000,
   localparam int             SEL_W      = $clog2(2 * N_RANGE),
   localparam int             LNK_W      = xwf_pkg::link_bits(N_RANGE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [SEL_W-1:0]    cfg_sel,
   input  logic [ADDR_W-1:0]   cfg_wdata,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic                in_long,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [N_RANGE-1:0]  lnk_free,
   output logic                pkt_valid,
   output logic [LNK_W-1:0]    pkt_link,
   output logic [ADDR_W-1:0]   pkt_addr,
   output logic                pkt_long,
   output logic [DATA_W-1:0]   pkt_data,
   output logic                csr_valid,
   output logic [ADDR_W-1:0]   csr_addr,
   input  logic [N_RANGE-1:0]  sts_valid,
   input  logic                sts_fail,
   output logic                unm_flag,
   output logic                err_flag,
   output logic                err_irq
);

   if (NODE_ID < 4 || NODE_ID > 8) begin : g_bad_node
      $error("xwf_forwarder: NODE_ID must be 4..8");
   end
   if (ADDR_W < 13 || ADDR_W > 64) begin : g_bad_addr
      $error("xwf_forwarder: ADDR_W out of range");
   end
   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_data
      $error("xwf_forwarder: DATA_W must be a multiple of 16");
   end
   if (N_RANGE < 1 || N_RANGE > 8) begin : g_bad_rng
      $error("xwf_forwarder: N_RANGE must be 1..8");
   end

   logic [N_RANGE-1:0][ADDR_W-1:0] lo_q;
   logic [N_RANGE-1:0][ADDR_W-1:0] hi_q;
   logic                           any_hit;
   logic [LNK_W-1:0]               hit_idx;

   xwf_range_regs #(.ADDR_W(ADDR_W), .N_RANGE(N_RANGE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .lo_q      (lo_q),
      .hi_q      (hi_q)
   );

   xwf_match #(.ADDR_W(ADDR_W), .N_RANGE(N_RANGE)) u_match (
      .addr    (in_addr),
      .lo_q    (lo_q),
      .hi_q    (hi_q),
      .any_hit (any_hit),
      .hit_idx (hit_idx)
   );

   xwf_ctrl #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .N_RANGE    (N_RANGE),
      .NODE_ID    (NODE_ID),
      .BCAST_BASE (BCAST_BASE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_addr   (in_addr),
      .in_long   (in_long),
      .in_data   (in_data),
      .any_hit   (any_hit),
      .hit_idx   (hit_idx),
      .in_ready  (in_ready),
      .lnk_free  (lnk_free),
      .sts_valid (sts_valid),
      .sts_fail  (sts_fail),
      .pkt_valid (pkt_valid),
      .pkt_link  (pkt_link),
      .pkt_addr  (pkt_addr),
      .pkt_long  (pkt_long),
      .pkt_data  (pkt_data),
      .csr_valid (csr_valid),
      .csr_addr  (csr_addr),
      .unm_flag  (unm_flag),
      .err_flag  (err_flag),
      .err_irq   (err_irq)
   );

   a_r1_window_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (any_hit && hit_idx == '0) |-> (in_addr >= lo_q[0] && in_addr <= hi_q[0]));

endmodule

// File: tb/xwf_forwarder_bench.sv
module xwf_forwarder_bench;

   localparam logic [39:0] BCAST = 40'hFF_8000_0000;
   localparam logic [39:0] EXP_CSR = BCAST + 40'h640;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = '0;
   logic [39:0]  cfg_wdata = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [39:0]  in_addr = '0;
   logic         in_long = 1'b0;
   logic [511:0] in_data = '0;
   logic [1:0]   lnk_free = '0;
   logic         pkt_valid;
   logic [0:0]   pkt_link;
   logic [39:0]  pkt_addr;
   logic         pkt_long;
   logic [511:0] pkt_data;
   logic         csr_valid;
   logic [39:0]  csr_addr;
   logic [1:0]   sts_valid = '0;
   logic         sts_fail = 1'b0;
   logic         unm_flag, err_flag, err_irq;

   int tests = 0;
   int fails = 0;
   bit chk_en = 1'b0;

   always #2.5 clk = ~clk;

   xwf_forwarder u_xwf_forwarder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_long(in_long),
      .in_data(in_data), .lnk_free(lnk_free), .pkt_valid(pkt_valid), .pkt_link(pkt_link),
      .pkt_addr(pkt_addr), .pkt_long(pkt_long), .pkt_data(pkt_data), .csr_valid(csr_valid),
      .csr_addr(csr_addr), .sts_valid(sts_valid), .sts_fail(sts_fail), .unm_flag(unm_flag),
      .err_flag(err_flag), .err_irq(err_irq));

   // ---------------- behavioural reference model ----------------
   logic [39:0]  m_lo [2];
   logic [39:0]  m_hi [2];
   int           m_ph;      // 0 empty, 1 waiting, 2 packet, 3 credit, 4 awaiting status
   int           m_link;
   logic [39:0]  m_addr;
   bit           m_long;
   logic [511:0] m_data;
   bit           m_unm, m_err, m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo[0] = '1; m_lo[1] = '1; m_hi[0] = '0; m_hi[1] = '0;
         m_ph = 0; m_link = 0; m_addr = '0; m_long = 0; m_data = '0;
         m_unm = 0; m_err = 0; m_irq = 0;
      end else begin
         m_irq = 0;
         case (m_ph)
            0: if (in_valid) begin
               if (in_addr >= m_lo[0] && in_addr <= m_hi[0]) begin
                  m_ph = 1; m_link = 0;
               end else if (in_addr >= m_lo[1] && in_addr <= m_hi[1]) begin
                  m_ph = 1; m_link = 1;
               end else m_unm = 1;
               if (m_ph == 1) begin
                  m_addr = in_addr; m_long = in_long;
                  m_data = in_long ? in_data : (in_data & {256'b0, {256{1'b1}}});
               end
            end
            1: if (lnk_free[m_link]) m_ph = 2;
            2: m_ph = 3;
            3: m_ph = 4;
            4: if (sts_valid[m_link]) begin
               m_ph = 0;
               if (sts_fail) begin m_err = 1; m_irq = 1; end
            end
            default: m_ph = 0;
         endcase
         if (cfg_we) begin
            if (cfg_sel[0]) m_hi[cfg_sel[1]] = cfg_wdata;
            else            m_lo[cfg_sel[1]] = cfg_wdata;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         chk(in_ready == (m_ph == 0), "R5 in_ready", 64'(in_ready), 64'(m_ph == 0));
         chk(pkt_valid == (m_ph == 2), "R6 pkt_valid", 64'(pkt_valid), 64'(m_ph == 2));
         chk(csr_valid == (m_ph == 3), "R8 csr_valid", 64'(csr_valid), 64'(m_ph == 3));
         chk(unm_flag == m_unm, "R4 unm_flag", 64'(unm_flag), 64'(m_unm));
         chk(err_flag == m_err, "R10 err_flag", 64'(err_flag), 64'(m_err));
         chk(err_irq == m_irq, "R10 err_irq", 64'(err_irq), 64'(m_irq));
         if (m_ph == 2) begin
            chk(pkt_link == 1'(m_link), "R2 pkt_link", 64'(pkt_link), 64'(m_link));
            chk(pkt_addr == m_addr, "R6 pkt_addr", 64'(pkt_addr), 64'(m_addr));
            chk(pkt_long == m_long, "R7 pkt_long", 64'(pkt_long), 64'(m_long));
            chk(pkt_data == m_data, "R7 pkt_data", pkt_data[511:448], m_data[511:448]);
         end
         if (m_ph == 3)
            chk(csr_addr == EXP_CSR, "R8 csr_addr", 64'(csr_addr), 64'(EXP_CSR));
      end
   end

   // ---------------- stimulus ----------------
   task automatic cfg(input logic [1:0] s, input logic [39:0] v);
      @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic offer(input logic [39:0] a, input bit lg, input logic [511:0] d);
      @(negedge clk); in_valid = 1; in_addr = a; in_long = lg; in_data = d;
      @(negedge clk); in_valid = 0;
   endtask

   task automatic txn(input logic [39:0] a, input bit lg, input logic [511:0] d,
                      input int hold, input bit fail, input int exp_link);
      lnk_free = 2'b00;
      offer(a, lg, d);
      // busy: this write must be ignored (R5)
      in_valid = 1; in_addr = a + 40'h10; in_long = ~lg; in_data = ~d;
      @(negedge clk); in_valid = 0;
      repeat (hold) @(negedge clk);
      chk(pkt_valid == 0, "R6 held while link busy", 64'(pkt_valid), 64'd0);
      lnk_free = 2'b11;
      for (int k = 0; k < 10 && !pkt_valid; k++) @(negedge clk);
      chk(pkt_link == 1'(exp_link), "R3 chosen link", 64'(pkt_link), 64'(exp_link));
      lnk_free = 2'b00;
      @(negedge clk);
      chk(csr_valid == 1, "R8 credit after packet", 64'(csr_valid), 64'd1);
      @(negedge clk);
      sts_valid = (exp_link == 0) ? 2'b10 : 2'b01; sts_fail = 0;
      @(negedge clk); sts_valid = 2'b00;
      chk(in_ready == 0, "R9 other-link status ignored", 64'(in_ready), 64'd0);
      sts_valid = (exp_link == 0) ? 2'b01 : 2'b10; sts_fail = fail;
      @(negedge clk); sts_valid = 2'b00; sts_fail = 0;
      chk(in_ready == 1, "R9 freed by status", 64'(in_ready), 64'd1);
      chk(err_irq == fail, "R10 irq pulse", 64'(err_irq), 64'(fail));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready == 1 && pkt_valid == 0 && csr_valid == 0 && unm_flag == 0 &&
          err_flag == 0 && err_irq == 0, "R11 reset state", 64'(in_ready), 64'd1);
      rst_n = 1;
      chk_en = 1;
      @(negedge clk);
      chk(in_ready == 1 && unm_flag == 0, "R11 after release", 64'(unm_flag), 64'd0);
      // R1: nothing matches before programming
      offer(40'h10_0000_0000, 0, '0);
      chk(unm_flag == 1, "R1 reset windows match nothing", 64'(unm_flag), 64'd1);
      chk(in_ready == 1, "R4 ready after drop", 64'(in_ready), 64'd1);
      cfg(2'd0, 40'h10_0000_0000);
      cfg(2'd1, 40'h10_FFFF_FFFF);
      cfg(2'd2, 40'h10_8000_0000);
      cfg(2'd3, 40'h20_0000_0000);
      // R2: window 0 low edge, short payload (R7)
      txn(40'h10_0000_0000, 0, {16{32'hA5A5_0001}}, 0, 0, 0);
      // R2: just above window 0, window 1 only, long payload
      txn(40'h11_0000_0000, 1, {16{32'h5A5A_0002}}, 3, 0, 1);
      // R2: window 1 high edge, failure status (R10)
      txn(40'h20_0000_0000, 1, {8{64'h0123_4567_89AB_CDEF}}, 1, 1, 1);
      // R3: overlap chooses link 0
      txn(40'h10_9000_0000, 0, {16{32'hC3C3_0004}}, 2, 0, 0);
      // R4: above all windows
      offer(40'h20_0000_0001, 1, '1);
      @(negedge clk);
      chk(pkt_valid == 0 && in_ready == 1, "R4 dropped write", 64'(pkt_valid), 64'd0);
      chk(err_flag == 1, "R10 sticky error", 64'(err_flag), 64'd1);
      repeat (3) @(negedge clk);
      chk_en = 0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule